// File: doc/BRIEF.md
# Control-Word Variable-Frequency Generator

This block turns a 16-bit control word into a periodic square-ish waveform for each of several channels. Every reference clock, a phase accumulator adds an increment that is derived from the word. The top bit of the accumulator is the output waveform, so the output frequency is the increment times 2^-16 of the reference clock. A second output emits a one-cycle tick on every rising edge of that waveform. A downstream constant-frequency pulse-width stage can use this tick as its time base. The waveform can also drive a pin directly.

Software loads the control word as two bytes, each with its own write strobe, into a register for each channel. A word in the lower half of the 16-bit range is used directly as the increment. A word with bit 15 set is first replaced by its 16-bit two's complement. A run input for each channel gates the accumulator. While run is low, the phase is held at zero, so every start begins from a known phase.

Top module: `varfreq_gen`

## Requirements
- R1: A cycle with `wr_hi[c]` high loads `wr_byte` into bits 15:8 of channel c's word, and a cycle with `wr_lo[c]` high loads it into bits 7:0. Each strobe leaves the other half unchanged.
- R2: For a word below 32768 the increment equals the word.
- R3: For a word of 32768 or more the increment is (65536 - word). For example, 0xF000 runs like 0x1000, 0x8000 advances by 32768, and 0xFFFF runs like 1.
- R4: With run high, the accumulator advances by the increment on every clock, modulo 65536. After k clocks with run high, `wave[c]` is 1 exactly when (k × increment mod 65536) ≥ 32768.
- R5: `tick[c]` is high for exactly the one cycle in which `wave[c]` has just changed from 0 to 1. It is never high in two consecutive cycles.
- R6: A word that is a power of two gives an exact 50% duty cycle. For example, 0x0800 gives 16 cycles high and 16 cycles low in every 32.
- R7: A word of 0 keeps `wave[c]` low and `tick[c]` low while the channel runs.
- R8: While `run[c]` is low, the accumulator is cleared, and `wave[c]` and `tick[c]` are low from the next clock onward. On restart the phase begins from zero.
- R9: Reset is synchronous and active low. It clears both halves of every word and the accumulators, so all outputs are low.
- R10: Channels are independent. Writes to one channel and the run state of one channel do not change another channel's outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run | input | NUM_CH | Per-channel run enable; low clears the phase |
| wr_hi | input | NUM_CH | Per-channel strobe that loads the upper byte of the word |
| wr_lo | input | NUM_CH | Per-channel strobe that loads the lower byte of the word |
| wr_byte | input | CW_W/2 | Byte written by either strobe |
| wave | output | NUM_CH | Accumulator top bit, the variable-frequency waveform |
| tick | output | NUM_CH | One-cycle pulse on each rising edge of `wave` |

## Verification
The assertions assume that reset is held low for at least two clocks before it is released. They also assume that the write strobes and the byte input are clean, known values at each rising edge. The bench keeps to these conditions by driving every input only on the falling clock edge and by holding reset low for several cycles. It writes the words only while the affected channel is stopped, so every run starts from a known word and from zero phase. Runs are kept short except for the word 0xFFFF, which needs 32768 cycles to reach its first rising edge.

// File: rtl/vfg_pkg.sv
// Package: shared constants and types for the variable-frequency generator.
// Assumes: control words are an even number of bits so they split into two halves.
package vfg_pkg;
    localparam int unsigned VFG_CW_W   = 16;
    localparam int unsigned VFG_NUM_CH = 2;
    typedef logic [VFG_CW_W-1:0] vfg_word_t;
endpackage

// File: rtl/vfg_cword_reg.sv
// Module: vfg_cword_reg
// Holds one channel's control word, written one half at a time.
// Assumes: strobes are synchronous to clk; both strobes in one cycle load both halves.
module vfg_cword_reg #(
    parameter int unsigned CW_W   = vfg_pkg::VFG_CW_W,
    localparam int unsigned HALF_W = CW_W / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_hi,
    input  logic              wr_lo,
    input  logic [HALF_W-1:0] wr_byte,
    output logic [CW_W-1:0]   cword
);

    // Load whichever halves are strobed; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cword <= '0;
        end else begin
            if (wr_hi) cword[CW_W-1:HALF_W] <= wr_byte;
            if (wr_lo) cword[HALF_W-1:0]    <= wr_byte;
        end
    end

    // R1: upper strobe lands the byte in the upper half
    assert_hi_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hi |=> cword[CW_W-1:HALF_W] == $past(wr_byte));

    // R1: lower half keeps its value without its own strobe
    assert_lo_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_lo |=> cword[HALF_W-1:0] == $past(cword[HALF_W-1:0]));

endmodule

// File: rtl/vfg_incr.sv
// Module: vfg_incr
// Derives the phase increment from the control word: the word itself in the
// lower half of the range, else its two's complement.
// Assumes: purely combinational; the caller registers nothing here.
module vfg_incr #(
    parameter int unsigned CW_W = vfg_pkg::VFG_CW_W
) (
    input  logic [CW_W-1:0] cword,
    output logic [CW_W-1:0] incr
);

    // Select the magnitude for words with the top bit set.
    always_comb begin
        if (cword[CW_W-1]) incr = (~cword) + 1'b1;
        else               incr = cword;
    end

endmodule

// File: rtl/vfg_accum.sv
// Module: vfg_accum
// Phase accumulator for one channel: adds the increment each clock while
// running, exposes the top bit as the waveform and flags its rising edges.
// Assumes: increment never exceeds half the accumulator range, so the top bit
// cannot rise on two consecutive clocks.
module vfg_accum #(
    parameter int unsigned CW_W = vfg_pkg::VFG_CW_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [CW_W-1:0] incr,
    output logic            wave,
    output logic            tick
);

    localparam logic [CW_W-1:0] HALF_SPAN = {1'b1, {(CW_W-1){1'b0}}};

    logic [CW_W-1:0] phase;
    logic            msb_d;

    // Advance the phase while running; hold it at zero otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n || !start) begin
            phase <= '0;
            msb_d <= 1'b0;
        end else begin
            phase <= phase + incr;
            msb_d <= phase[CW_W-1];
        end
    end

    // Waveform is the phase top bit; tick marks its 0-to-1 step.
    always_comb begin
        wave = phase[CW_W-1];
        tick = phase[CW_W-1] & ~msb_d;
    end

    // R8: stopped channel is cleared on the next clock
    assert_idle_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> (phase == '0 && !wave && !tick));

    // R5: tick never lasts two cycles
    assert_tick_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

    // R5: tick only where the waveform has just risen
    assert_tick_edge_R5: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> (wave && !$past(wave)));

    // R3: derived increment stays within half the range
    assert_incr_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        incr <= HALF_SPAN);

    // R7: zero increment from zero phase stays at zero
    assert_zero_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (start && incr == '0 && phase == '0) |=> (phase == '0 && !wave));

endmodule

// File: rtl/varfreq_gen.sv
// Module: varfreq_gen
// Multi-channel control-word variable-frequency generator: per channel a
// byte-written word register, increment derivation and phase accumulator.
// Assumes: all channels share one reference clock and one write byte bus.
module varfreq_gen #(
    parameter int unsigned NUM_CH = vfg_pkg::VFG_NUM_CH,
    parameter int unsigned CW_W   = vfg_pkg::VFG_CW_W,
    localparam int unsigned HALF_W = CW_W / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] run,
    input  logic [NUM_CH-1:0] wr_hi,
    input  logic [NUM_CH-1:0] wr_lo,
    input  logic [HALF_W-1:0] wr_byte,
    output logic [NUM_CH-1:0] wave,
    output logic [NUM_CH-1:0] tick
);

    // One independent generator slice per channel.
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic [CW_W-1:0] cword;
        logic [CW_W-1:0] incr;

        vfg_cword_reg #(.CW_W(CW_W)) u_word (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_hi   (wr_hi[c]),
            .wr_lo   (wr_lo[c]),
            .wr_byte (wr_byte),
            .cword   (cword)
        );

        vfg_incr #(.CW_W(CW_W)) u_incr (
            .cword (cword),
            .incr  (incr)
        );

        vfg_accum #(.CW_W(CW_W)) u_acc (
            .clk   (clk),
            .rst_n (rst_n),
            .start (run[c]),
            .incr  (incr),
            .wave  (wave[c]),
            .tick  (tick[c])
        );
    end

endmodule

// File: tb/tb_varfreq_gen.sv
// Directed bench for varfreq_gen: each task drives one scenario and checks it
// against a phase model computed from the requirements.
module tb_varfreq_gen;
    localparam int CLK_P   = 10;
    localparam int NCH     = 2;
    localparam int WD_CYC  = 200000;

    logic            clk = 1'b0;
    logic            rst_n;
    logic [NCH-1:0]  run, wr_hi, wr_lo;
    logic [7:0]      wr_byte;
    logic [NCH-1:0]  wave, tick;

    int n_chk = 0;
    int n_bad = 0;
    logic [15:0] word_m [NCH];

    always #(CLK_P/2) clk = ~clk;

    varfreq_gen #(.NUM_CH(NCH), .CW_W(16)) dut (
        .clk(clk), .rst_n(rst_n), .run(run), .wr_hi(wr_hi), .wr_lo(wr_lo),
        .wr_byte(wr_byte), .wave(wave), .tick(tick)
    );

    function automatic longint eff(input logic [15:0] w);
        if (w < 16'h8000) return longint'(w);
        return 65536 - longint'(w);
    endfunction

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    task automatic wr_half(input int ch, input bit hi, input logic [7:0] b);
        @(negedge clk);
        wr_byte = b;
        if (hi) begin wr_hi[ch] = 1'b1; word_m[ch][15:8] = b; end
        else    begin wr_lo[ch] = 1'b1; word_m[ch][7:0]  = b; end
        @(negedge clk);
        wr_hi = '0; wr_lo = '0;
    endtask

    task automatic wr_word(input int ch, input logic [15:0] w);
        wr_half(ch, 1'b1, w[15:8]);
        wr_half(ch, 1'b0, w[7:0]);
    endtask

    // Run the enabled channels for n clocks from zero phase, compare every cycle.
    task automatic run_chk(input bit en0, input bit en1, input int n, input string req,
                           output int hi0);
        longint w [NCH];
        int wmis [NCH], tact [NCH], texp [NCH], dbl [NCH];
        bit pw [NCH], ptk [NCH];
        bit en [NCH];
        en[0] = en0; en[1] = en1;
        hi0 = 0;
        for (int c = 0; c < NCH; c++) begin
            w[c] = eff(word_m[c]); wmis[c] = 0; tact[c] = 0; texp[c] = 0;
            dbl[c] = 0; pw[c] = 0; ptk[c] = 0;
        end
        @(negedge clk);
        run = {en1, en0};
        for (int j = 1; j <= n; j++) begin
            @(negedge clk);
            for (int c = 0; c < NCH; c++) begin
                bit ew, et;
                ew = en[c] ? (((longint'(j) * w[c]) % 65536) >= 32768) : 1'b0;
                et = ew && !pw[c];
                if (wave[c] !== ew) wmis[c]++;
                if (tick[c] === 1'b1) tact[c]++;
                if (et) texp[c]++;
                if (tick[c] === 1'b1 && ptk[c]) dbl[c]++;
                pw[c] = ew; ptk[c] = (tick[c] === 1'b1);
            end
            if (wave[0] === 1'b1) hi0++;
        end
        for (int c = 0; c < NCH; c++) begin
            check(wmis[c] == 0, {req, " R4 wave trace"}, wmis[c], 0);
            check(tact[c] == texp[c], {req, " R5 tick count"}, tact[c], texp[c]);
            check(dbl[c] == 0, {req, " R5 no back-to-back tick"}, dbl[c], 0);
        end
    endtask

    task automatic stop_all();
        @(negedge clk);
        run = '0;
        @(negedge clk);
        check(wave == '0 && tick == '0, "R8 outputs low after stop", {wave, tick}, 0);
    endtask

    task automatic t_reset();
        int h;
        rst_n = 1'b0; run = '0; wr_hi = '0; wr_lo = '0; wr_byte = '0;
        for (int c = 0; c < NCH; c++) word_m[c] = '0;
        repeat (4) @(negedge clk);
        check(wave == '0 && tick == '0, "R9 outputs low in reset", {wave, tick}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(wave == '0 && tick == '0, "R9 outputs low after reset", {wave, tick}, 0);
        // Word is zero after reset: running keeps everything low (R7, R9).
        run_chk(1'b1, 1'b1, 60, "R7 R9 zero word", h);
        check(h == 0, "R7 wave never high", h, 0);
        stop_all();
    endtask

    task automatic t_bytes();
        int h;
        wr_half(0, 1'b1, 8'h12);
        wr_half(0, 1'b0, 8'h34);
        run_chk(1'b1, 1'b0, 200, "R1 word 0x1234", h);
        stop_all();
        wr_half(0, 1'b1, 8'h00);   // lower half must survive
        run_chk(1'b1, 1'b0, 1500, "R1 upper rewrite keeps 0x34", h);
        stop_all();
        wr_half(0, 1'b0, 8'h80);   // upper half must survive -> 0x0080
        run_chk(1'b1, 1'b0, 1100, "R1 lower rewrite keeps 0x00", h);
        stop_all();
    endtask

    task automatic t_direct();
        int h;
        wr_word(0, 16'h0100);
        run_chk(1'b1, 1'b0, 600, "R2 word 0x0100", h);
        stop_all();
        wr_word(0, 16'h0123);
        run_chk(1'b1, 1'b0, 800, "R2 word 0x0123", h);
        stop_all();
    endtask

    task automatic t_duty();
        int h;
        wr_word(0, 16'h0800);
        run_chk(1'b1, 1'b0, 64, "R6 word 0x0800", h);
        check(h == 32, "R6 high cycles in 64", h, 32);
        stop_all();
    endtask

    task automatic t_negative();
        int h;
        wr_word(0, 16'hF000);
        run_chk(1'b1, 1'b0, 100, "R3 word 0xF000", h);
        check(h == 48, "R3 0xF000 high cycles in 100", h, 48);
        stop_all();
        wr_word(0, 16'h8000);
        run_chk(1'b1, 1'b0, 40, "R3 word 0x8000", h);
        check(h == 20, "R3 0x8000 toggles each clock", h, 20);
        stop_all();
        wr_word(0, 16'hFFFF);
        run_chk(1'b1, 1'b0, 32770, "R3 word 0xFFFF", h);
        check(h == 3, "R3 0xFFFF rises at cycle 32768", h, 3);
        stop_all();
    endtask

    task automatic t_stop();
        int h;
        wr_word(0, 16'h0700);
        run_chk(1'b1, 1'b0, 20, "R8 first run", h);
        check(wave[0] === 1'b1, "R8 wave high before stop", wave[0], 1);
        stop_all();
        run_chk(1'b1, 1'b0, 50, "R8 restart from zero phase", h);
        stop_all();
    endtask

    task automatic t_channels();
        int h;
        wr_word(0, 16'h0300);
        wr_word(1, 16'hE000);
        run_chk(1'b1, 1'b1, 300, "R10 both channels", h);
        stop_all();
        run_chk(1'b0, 1'b1, 200, "R10 channel 1 alone", h);
        check(h == 0, "R10 stopped channel 0 stays low", h, 0);
        stop_all();
        wr_word(1, 16'h0040);      // rewrite channel 1 only
        run_chk(1'b1, 1'b0, 300, "R10 channel 0 after channel 1 write", h);
        stop_all();
    endtask

    initial begin
        t_reset();
        t_bytes();
        t_direct();
        t_duty();
        t_negative();
        t_stop();
        t_channels();
        summary();
        $finish;
    end

    initial begin
        repeat (WD_CYC) @(posedge clk);
        check(1'b0, "watchdog expired", 0, 1);
        summary();
        $finish;
    end

endmodule